// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

The block is a 32-bit down-counter that raises a single-cycle interrupt request when its count runs out. Counting is paced by a power-of-two prescaler placed on the bus clock. Software sets the prescale ratio, the start count and a control word through a small register port. The control word holds the interrupt vector, a mask and the choice between one-shot and periodic operation. The current count can be read back at any time.

A write to the start count loads the counter and restarts the prescaler. In one-shot mode the count falls to zero and stays there, and one request is raised on the tick after zero is reached. In periodic mode the counter reloads itself after zero, so each period lasts start count plus one ticks and one request is raised per period. A start count of zero never raises a request.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset the divide register reads 0, the control word reads 0x0001_0000 (masked, one-shot, vector 0), the start count and the current count read 0, and `irq_valid` is low.
- R2: Register address 0 is the divide register. It keeps only write-data bits 3, 1 and 0 and reads the other bits as 0. A code v = {bit3, bit1, bit0} gives a prescale shift of (v+1) mod 8, so one tick occurs every 2^shift clocks. Code 7 ticks every clock, and bit 2 has no effect.
- R3: Register address 1 is the control word. Bit 17 selects periodic mode (1) or one-shot mode (0), bit 16 is the mask, and bits 7:0 are the vector. All other bits read 0.
- R4: A write to address 2 (start count) loads the current count with the written value and clears the prescaler. The count then drops by one every 2^shift clocks, and the first decrement lands exactly 2^shift clocks after the write edge.
- R5: In one-shot mode, after a load of N > 0 the current count (address 3) reads N minus the elapsed ticks, saturating at 0. Exactly one request is raised, on the edge (N+1)·2^shift clocks after the load, and none after that.
- R6: In periodic mode, after a load of N > 0 the count reads N − (ticks mod (N+1)). A request is raised at the end of every period of N+1 ticks.
- R7: A start count of 0 produces no request in either mode.
- R8: The mask is sampled at each expiry. A masked expiry raises no request but still consumes the one-shot expiry and still restarts the periodic period. Clearing the mask lets the next periodic expiry raise a request.
- R9: `irq_valid` is high for one clock, in the cycle right after the expiry edge. `irq_vector` carries the vector held in the control word before that edge.
- R10: If a start-count write lands on the same edge as an expiry, the load wins. No request is raised and counting restarts from the new value.
- R11: The current-count register (address 3) is read only. A write to it changes neither the count nor the timing of requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write takes effect on the next rising edge |
| bus_addr | input | 2 | Register select: 0 divide, 1 control, 2 start count, 3 current count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with the request |

## Verification
Two events can fall on the same edge: a reload from a start-count write and the expiry of the running count. The bench provokes this by tracking, in its own model, the clocks elapsed since the last load. It waits until the next edge is a periodic expiry and then issues a start-count write on exactly that edge. The outcome is judged as correct only if no request appears in the following cycle and the current count then follows the new value from a fresh prescaler phase. A second overlap, a control-word write on an expiry edge, is judged by requiring that the expiry use the control-word value stored before that edge.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int ADDR_W   = 2;
    localparam int DIV_W    = 4;
    localparam int SHIFT_W  = 3;
    localparam int MODE_BIT = 17;
    localparam int MASK_BIT = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIV  = 2'd0,
        REG_CTRL = 2'd1,
        REG_INIT = 2'd2,
        REG_CUR  = 2'd3
    } reg_sel_e;

    // prescale shift from the scattered divide code {b3,b1,b0}, plus one, wrapping
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_W-1:0] code);
        logic [SHIFT_W-1:0] v;
        v = {code[3], code[1], code[0]};
        return v + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/ct_regs.sv
module ct_regs
    import ct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DIV_W-1:0]   div_code,
    output logic [SHIFT_W-1:0] shift,
    output logic               periodic,
    output logic               masked,
    output logic [VEC_W-1:0]   vector,
    output logic [DATA_W-1:0]  init_val,
    output logic               load
);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              periodic;
        logic              masked;
        logic [VEC_W-1:0]  vec;
        logic [DATA_W-1:0] init;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        load   = 1'b0;
        if (wr_en) begin
            case (reg_sel_e'(addr))
                REG_DIV: begin
                    regs_d.div = {wdata[3], 1'b0, wdata[1:0]};
                end
                REG_CTRL: begin
                    regs_d.periodic = wdata[MODE_BIT];
                    regs_d.masked   = wdata[MASK_BIT];
                    regs_d.vec      = wdata[VEC_W-1:0];
                end
                REG_INIT: begin
                    regs_d.init = wdata;
                    load        = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.div      <= '0;
            regs_q.periodic <= 1'b0;
            regs_q.masked   <= 1'b1;
            regs_q.vec      <= '0;
            regs_q.init     <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign div_code = regs_q.div;
    assign shift    = div_shift(regs_q.div);
    assign periodic = regs_q.periodic;
    assign masked   = regs_q.masked;
    assign vector   = regs_q.vec;
    assign init_val = regs_q.init;

endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler
    import ct_pkg::*;
#(
    parameter int PSH_W = SHIFT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSH_W-1:0] shift,
    input  logic             restart,
    output logic             tick
);

    localparam int PRE_W = (1 << PSH_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W:0]   span_m1;
    logic [PRE_W-1:0] limit;

    always_comb begin
        span    = (PRE_W+1)'(1) << shift;
        span_m1 = span - (PRE_W+1)'(1);
        limit   = span_m1[PRE_W-1:0];
        tick    = (pre_q.cnt >= limit);
        pre_d   = pre_q;
        if (restart || tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/ct_core.sv
module ct_core #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] cur,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);

    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             armed;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d     = core_q;
        core_d.irq = 1'b0;
        if (load) begin
            core_d.cur   = load_val;
            core_d.armed = (load_val != '0);
        end else if (tick) begin
            if (core_q.cur != '0) begin
                core_d.cur = core_q.cur - CNT_W'(1);
            end else if (core_q.armed) begin
                if (periodic) begin
                    core_d.cur = reload_val;
                end else begin
                    core_d.armed = 1'b0;
                end
                if (!masked) begin
                    core_d.irq = 1'b1;
                    core_d.vec = vector;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cur        = core_q.cur;
    assign irq_valid  = core_q.irq;
    assign irq_vector = core_q.vec;

endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer
    import ct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [DIV_W-1:0]   div_code;
    logic [SHIFT_W-1:0] shift;
    logic               periodic;
    logic               masked;
    logic [VEC_W-1:0]   vector;
    logic [DATA_W-1:0]  init_val;
    logic               load;
    logic               tick;
    logic [DATA_W-1:0]  cur_count;

    ct_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .div_code (div_code),
        .shift    (shift),
        .periodic (periodic),
        .masked   (masked),
        .vector   (vector),
        .init_val (init_val),
        .load     (load)
    );

    ct_prescaler #(.PSH_W(SHIFT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (shift),
        .restart (load),
        .tick    (tick)
    );

    ct_core #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (load),
        .load_val   (bus_wdata),
        .reload_val (init_val),
        .periodic   (periodic),
        .masked     (masked),
        .vector     (vector),
        .cur        (cur_count),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            REG_DIV:  bus_rdata[DIV_W-1:0] = div_code;
            REG_CTRL: begin
                bus_rdata[MODE_BIT]  = periodic;
                bus_rdata[MASK_BIT]  = masked;
                bus_rdata[VEC_W-1:0] = vector;
            end
            REG_INIT: bus_rdata = init_val;
            REG_CUR:  bus_rdata = cur_count;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             tick,
    input logic [CNT_W-1:0] cur,
    input logic             periodic,
    input logic             masked,
    input logic             irq_valid,
    input logic [CNT_W-1:0] wdata
);

    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur == $past(wdata)));

    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cur));

    a_r5_saturate_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !periodic && cur == '0) |=> (cur == '0));

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    a_r9_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ($past(tick) && $past(cur) == '0));

    a_r8_mask_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(masked));

    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !irq_valid);

endmodule

bind countdown_irq_timer ct_checker #(.CNT_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .tick      (tick),
    .cur       (cur_count),
    .periodic  (periodic),
    .masked    (masked),
    .irq_valid (irq_valid),
    .wdata     (bus_wdata)
);

// File: tb/countdown_irq_timer_tb.sv
module countdown_irq_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd3;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    countdown_irq_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    int    pulses = 0;
    int    cycles = 0;
    bit    done = 0;
    string phase = "R1";

    // behavioural reference state
    bit         m_loaded;
    longint     m_c;
    longint     m_n;
    bit [3:0]   m_div;
    bit         m_per;
    bit         m_mask;
    bit [7:0]   m_vec;
    bit         exp_irq;
    bit [7:0]   exp_vec;

    function automatic longint ticks_per();
        int v;
        v = {m_div[3], m_div[1], m_div[0]};
        return longint'(1) << ((v + 1) % 8);
    endfunction

    function automatic longint exp_count();
        longint d;
        if (!m_loaded) return 0;
        d = m_c / ticks_per();
        if (m_per) return m_n - (d % (m_n + 1));
        return (d >= m_n) ? 0 : m_n - d;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // model update at the edge, comparison a quarter period later
    always begin
        @(posedge clk);
        if (!rst_n) begin
            m_loaded = 0; m_c = 0; m_n = 0; m_div = 0;
            m_per = 0; m_mask = 1; m_vec = 0; exp_irq = 0;
        end else begin
            exp_irq = 0;
            if (bus_wr && bus_addr == 2'd2) begin
                m_loaded = 1; m_c = 0; m_n = longint'(bus_wdata);
            end else if (m_loaded) begin
                longint span;
                m_c++;
                span = (m_n + 1) * ticks_per();
                if (m_n != 0 && (m_c % span) == 0 && (m_per || m_c == span)) begin
                    if (!m_mask) begin
                        exp_irq = 1;
                        exp_vec = m_vec;
                    end
                end
            end
            if (bus_wr && bus_addr == 2'd0) m_div = {bus_wdata[3], 1'b0, bus_wdata[1:0]};
            if (bus_wr && bus_addr == 2'd1) begin
                m_per  = bus_wdata[17];
                m_mask = bus_wdata[16];
                m_vec  = bus_wdata[7:0];
            end
        end
        #(CLK_PERIOD/4);
        check({31'd0, irq_valid}, {31'd0, exp_irq}, phase, "irq_valid");
        if (exp_irq) check({24'd0, irq_vector}, {24'd0, exp_vec}, phase, "irq_vector");
        if (irq_valid) pulses++;
        if (bus_addr == 2'd3 && !bus_wr)
            check(bus_rdata, 32'(exp_count()), phase, "current count");
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, tag, "readback");
        bus_addr = 2'd3;
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic park();
        wr(2'd2, 32'd0);
        wait_clk(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        logic [3:0] codes [6];
        int         spans [6];
        codes = '{4'h7, 4'h8, 4'hB, 4'h2, 4'h6, 4'hA};
        spans = '{16, 32, 1, 8, 8, 128};

        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        phase = "R1";
        rd(2'd0, 32'h0, "R1");
        rd(2'd1, 32'h0001_0000, "R1");
        rd(2'd2, 32'h0, "R1");
        rd(2'd3, 32'h0, "R1");

        // R2 / R3 field masking
        phase = "R2";
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'h0000_000B, "R2");
        phase = "R3";
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 32'h0003_00FF, "R3");
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0000_0041);
        rd(2'd1, 32'h0000_0041, "R3");

        // R4 / R5 one-shot at divide by two
        phase = "R5";
        wr(2'd2, 32'd5);
        rd(2'd2, 32'd5, "R4");
        pulses = 0;
        wait_clk(30);
        check(pulses, 1, "R5", "one-shot pulse count");
        wait_clk(20);
        check(pulses, 1, "R5", "one-shot stays silent");

        // R2 / R4 divide codes, one-shot of 3
        phase = "R2";
        for (int k = 0; k < 6; k++) begin
            park();
            wr(2'd0, {28'd0, codes[k]});
            phase = "R4";
            wr(2'd2, 32'd3);
            pulses = 0;
            wait_clk(5 * spans[k] + 4);
            check(pulses, 1, "R2", "pulses for divide code");
            phase = "R2";
        end

        // R6 periodic, R11 write to current count ignored
        park();
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0002_005A);
        phase = "R6";
        wr(2'd2, 32'd3);
        pulses = 0;
        wait_clk(42);
        check(pulses, 5, "R6", "periodic pulse count");
        phase = "R11";
        wr(2'd3, 32'h0001_2345);
        pulses = 0;
        wait_clk(40);
        check(pulses, 5, "R11", "periodic pulses after read-only write");

        // R7 zero start count in both modes
        phase = "R7";
        wr(2'd2, 32'd0);
        pulses = 0;
        wait_clk(40);
        check(pulses, 0, "R7", "periodic zero count pulses");
        wr(2'd1, 32'h0000_005A);
        wr(2'd2, 32'd0);
        pulses = 0;
        wait_clk(40);
        check(pulses, 0, "R7", "one-shot zero count pulses");

        // R8 mask, then unmask
        phase = "R8";
        wr(2'd1, 32'h0003_005A);
        wr(2'd2, 32'd3);
        pulses = 0;
        wait_clk(40);
        check(pulses, 0, "R8", "masked periodic pulses");
        wr(2'd1, 32'h0002_00C3);
        pulses = 0;
        wait_clk(40);
        check(pulses, 5, "R8", "pulses after unmask");

        // R9 control write on an expiry edge: old vector used
        phase = "R9";
        park();
        wr(2'd1, 32'h0002_0011);
        wr(2'd2, 32'd1);
        while (m_c != 3) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0002_0022;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3;
        check({24'd0, irq_vector}, 32'h11, "R9", "vector on coinciding control write");
        wait_clk(10);

        // R10 reload on an expiry edge
        phase = "R10";
        wr(2'd2, 32'd3);
        while (m_c != 15) @(negedge clk);
        pulses = 0;
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'd2;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3;
        wait_clk(1);
        check(pulses, 0, "R10", "pulse on reload collision");
        wait_clk(30);

        finish_run();
    end

endmodule